// File: doc/BRIEF.md
# Subtract-Only Accumulator Processor Core

This block is a small stored-program processor. It keeps a single 32-bit accumulator, a 5-bit program counter and a 32-bit instruction register. It runs seven instruction kinds out of one 32-word memory that holds both code and data. The only arithmetic is subtraction. Every load stores the two's-complement negation of the word it reads. A jump takes its destination from a memory cell instead of from the instruction.

Each instruction takes eight clock cycles, and a 3-bit slot counter marks where the core is inside that window. In slot 0 the program counter is incremented. In slots 1 and 2 the memory is addressed by the program counter, and the fetched word is captured in the instruction register at the end of slot 2. In slots 3 and 4 the memory is addressed by the operand. Slots 5 to 7 are idle. The memory sits outside the core behind one port, and its read data may arrive up to one cycle after the address. Because the counter is incremented before each fetch, a jump to value V continues execution at V+1.

After reset the core waits until `start` is pulsed. It then runs until it decodes a halt, lights `halted` and waits again. Programs are written into the memory by its owner while the core is idle. The core has no data stream interface: every pin is a plain control, status or memory-port signal.

Top module: `subacc_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the program counter, the instruction register and the accumulator to 0 and deasserts `halted`. The core then stays idle with `mem_we` low and an unchanged program counter until `start` is seen high at a clock edge.
- R2: The opcode is instruction bits 15:13 and the operand is bits 12:0. Only operand bits 4:0 address memory. Bits 31:16 and 12:5 have no effect. The codes are 0 indirect jump, 1 relative jump, 2 negating load, 3 store, 4 subtract, 6 skip-if-negative and 7 halt.
- R3: A negating load (code 2) sets the accumulator to 0 minus the addressed word, modulo 2^32. The most negative word therefore loads as itself.
- R4: A subtract (code 4) sets the accumulator to the accumulator minus the addressed word, wrapping modulo 2^32. Code 5 behaves exactly like code 4.
- R5: A store (code 3) writes the accumulator to the addressed word with one write strobe and leaves the accumulator unchanged. No other instruction writes memory.
- R6: An indirect jump (code 0) loads the program counter with bits 4:0 of the addressed word, so the next instruction comes from that value plus one.
- R7: A relative jump (code 1) adds bits 4:0 of the addressed word to the program counter, modulo 32. The next instruction comes from that sum plus one.
- R8: Skip-if-negative (code 6) advances the program counter by one more when accumulator bit 31 is set, which skips the next instruction. Otherwise it has no effect.
- R9: Halt (code 7) raises `halted` and stops execution, with the program counter left at the address of the halt. While halted, the program counter and accumulator hold and memory is not written. A later `start` clears `halted` and resumes at the following address.
- R10: Every non-halting instruction takes exactly 8 cycles. `halted` rises 4 clock edges after the edge that started the halt instruction's window, so a program of N instructions ending in a halt halts 8(N-1)+4 edges after the start edge.
- R11: The program counter is 5 bits wide and wraps from 31 to 0 on its pre-fetch increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins or resumes execution when the core is idle |
| mem_addr | output | 5 | Memory word address |
| mem_wdata | output | 32 | Memory write data (accumulator) |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Memory read data, at most one cycle after the address |
| halted | output | 1 | Stop indication after a halt instruction |
| dbg_pc | output | 5 | Program counter view |
| dbg_ir | output | 32 | Instruction register view |
| dbg_acc | output | 32 | Accumulator view |

## Verification
The bench targets the off-by-one in jump targets. A core that jumped straight to the cell value instead of value plus one would halt on a decoy instruction placed at the wrong address. Skip-if-negative is run with both signs, so inverted sign sensing or an unconditional skip lands on the wrong halt. Negating the most negative word and wrapping the program counter past 31 catch saturating arithmetic and a counter wider than five bits. Instruction words carry set bits in every ignored field, and the halt edge is counted from the start edge, so field decoding from the wrong bits or a missing or extra sequencer slot shows up as a wrong accumulator, address or cycle count.

// File: rtl/subacc_pkg.sv
package subacc_pkg;

  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int OPC_W    = 3;
  localparam int OPC_LSB  = 13;
  localparam int SLOT_W   = 3;

  // Slot numbers inside the eight-cycle window
  localparam logic [SLOT_W-1:0] SLOT_INC  = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_IRLD = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_EX1  = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_EX2  = 3'd4;

  typedef enum logic [OPC_W-1:0] {
    OPC_JIND = 3'd0,
    OPC_JREL = 3'd1,
    OPC_LNEG = 3'd2,
    OPC_STOR = 3'd3,
    OPC_SUBT = 3'd4,
    OPC_SUBA = 3'd5,
    OPC_SKNG = 3'd6,
    OPC_STOP = 3'd7
  } opc_e;

  typedef struct packed {
    logic jind;
    logic jrel;
    logic lneg;
    logic stor;
    logic subt;
    logic skng;
    logic stop;
  } dec_t;

endpackage

// File: rtl/subacc_seq.sv
module subacc_seq
  import subacc_pkg::*;
#(
  parameter int SW = SLOT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          halt_req,
  output logic          running,
  output logic          halted,
  output logic [SW-1:0] slot_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      halted  <= 1'b0;
      slot_q  <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        halted  <= 1'b0;
        slot_q  <= '0;
      end
    end else if (halt_req) begin
      running <= 1'b0;
      halted  <= 1'b1;
      slot_q  <= '0;
    end else begin
      slot_q <= slot_q + 1'b1;
    end
  end

  // R1: reset leaves the sequencer idle and not halted
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!running && !halted && slot_q == '0));

  // R9: a halted core never runs
  a_r9_halt_not_running: assert property (@(posedge clk) disable iff (rst)
    halted |-> !running);

endmodule

// File: rtl/subacc_decode.sv
module subacc_decode
  import subacc_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output dec_t             dec
);

  always_comb begin
    dec = '0;
    unique case (opc_e'(opc))
      OPC_JIND: dec.jind = 1'b1;
      OPC_JREL: dec.jrel = 1'b1;
      OPC_LNEG: dec.lneg = 1'b1;
      OPC_STOR: dec.stor = 1'b1;
      OPC_SUBT,
      OPC_SUBA: dec.subt = 1'b1;
      OPC_SKNG: dec.skng = 1'b1;
      OPC_STOP: dec.stop = 1'b1;
      default:  dec = '0;
    endcase
  end

endmodule

// File: rtl/subacc_alu.sv
module subacc_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         negate,
  output logic [W-1:0] res
);

  // Negation is 0 - rhs; both wrap modulo 2^W
  assign res = (negate ? {W{1'b0}} : lhs) - rhs;

endmodule

// File: rtl/subacc_datapath.sv
module subacc_datapath
  import subacc_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_inc,
  input  logic          st_irld,
  input  logic          st_ex1,
  input  logic          st_ex2,
  input  logic          is_jind,
  input  logic          is_jrel,
  input  logic          is_lneg,
  input  logic          is_stor,
  input  logic          is_subt,
  input  logic          is_skng,
  input  logic [AW-1:0] opnd_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] acc,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we
);

  logic [DW-1:0] alu_res;
  logic          acc_neg;

  assign acc_neg = acc[DW-1];

  subacc_alu #(.W(DW)) u_alu (
    .lhs    (acc),
    .rhs    (mem_rdata),
    .negate (is_lneg),
    .res    (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (st_inc) begin
      pc <= pc + 1'b1;
    end else if (st_ex1 && is_skng && acc_neg) begin
      pc <= pc + 1'b1;
    end else if (st_ex2 && is_jind) begin
      pc <= mem_rdata[AW-1:0];
    end else if (st_ex2 && is_jrel) begin
      pc <= pc + mem_rdata[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir <= '0;
    end else if (st_irld) begin
      ir <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (st_ex2 && (is_lneg || is_subt)) begin
      acc <= alu_res;
    end
  end

  assign mem_addr  = (st_ex1 || st_ex2) ? opnd_addr : pc;
  assign mem_we    = st_ex1 && is_stor;
  assign mem_wdata = acc;

  // R5: a write goes to the operand cell and carries the accumulator
  a_r5_write_target: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == ir[AW-1:0] && mem_wdata == acc));

  // R10: the instruction register only changes on its capture slot
  a_r10_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !st_irld |=> $stable(ir));

  // R6: an indirect jump takes the cell value as the new counter
  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    (st_ex2 && is_jind) |=> pc == $past(mem_rdata[AW-1:0]));

  // R8: a non-negative accumulator makes the skip a no-op
  a_r8_no_skip: assert property (@(posedge clk) disable iff (rst)
    (st_ex1 && is_skng && !acc_neg) |=> $stable(pc));

endmodule

// File: rtl/subacc_core.sv
module subacc_core
  import subacc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  output logic                 mem_we,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 halted,
  output logic [ADDR_W-1:0]    dbg_pc,
  output logic [WORD_W-1:0]    dbg_ir,
  output logic [WORD_W-1:0]    dbg_acc
);

  logic              running;
  logic [SLOT_W-1:0] slot_q;
  logic              st_inc, st_irld, st_ex1, st_ex2;
  dec_t              dec;
  logic [ADDR_W-1:0] pc;
  logic [WORD_W-1:0] ir, acc;

  assign st_inc  = running && (slot_q == SLOT_INC);
  assign st_irld = running && (slot_q == SLOT_IRLD);
  assign st_ex1  = running && (slot_q == SLOT_EX1);
  assign st_ex2  = running && (slot_q == SLOT_EX2);

  subacc_seq #(.SW(SLOT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .halt_req (st_ex1 && dec.stop),
    .running  (running),
    .halted   (halted),
    .slot_q   (slot_q)
  );

  subacc_decode u_dec (
    .opc (ir[OPC_LSB +: OPC_W]),
    .dec (dec)
  );

  subacc_datapath #(.DW(WORD_W), .AW(ADDR_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .st_inc    (st_inc),
    .st_irld   (st_irld),
    .st_ex1    (st_ex1),
    .st_ex2    (st_ex2),
    .is_jind   (dec.jind),
    .is_jrel   (dec.jrel),
    .is_lneg   (dec.lneg),
    .is_stor   (dec.stor),
    .is_subt   (dec.subt),
    .is_skng   (dec.skng),
    .opnd_addr (ir[ADDR_W-1:0]),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .ir        (ir),
    .acc       (acc),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we)
  );

  assign dbg_pc  = pc;
  assign dbg_ir  = ir;
  assign dbg_acc = acc;

  // R9: a halted core leaves memory untouched
  a_r9_quiet_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  // R9: counter and accumulator freeze while halted
  a_r9_freeze: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> ($stable(dbg_pc) && $stable(dbg_acc)));

endmodule

// File: tb/tb_subacc_core.sv
`timescale 1ns/1ps
module tb_subacc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_we;
  logic [31:0] mem_rdata;
  logic        halted;
  logic [4:0]  dbg_pc;
  logic [31:0] dbg_ir;
  logic [31:0] dbg_acc;

  logic [31:0] mem [32];
  logic        ld_en = 1'b0;
  logic [4:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          wr_cnt = 0;

  always #2.5 clk = ~clk;

  subacc_core dut (
    .clk(clk), .rst(rst), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .halted(halted),
    .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_acc(dbg_acc)
  );

  // Memory model: registered read, one-cycle latency
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [31:0] ins(input int opc, input int opnd);
    return (32'(opc) << 13) | 32'(opnd);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 5'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic fill_halt();
    for (int i = 0; i < 32; i++) poke(i, ins(7, 0));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  // Returns clock edges from the start edge to the halt edge
  task automatic run_prog(output int ticks);
    int c;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    c = 1;
    while (!halted && c < 3000) begin
      @(negedge clk);
      c++;
    end
    ticks = c - 1;
    if (!halted) begin
      n_chk++; n_fail++;
      $display("FAIL R9 no halt actual=0 expected=1");
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 pc", 32'(dbg_pc), 0);
    check("R1 ir", dbg_ir, 0);
    check("R1 acc", dbg_acc, 0);
    check("R1 halted", 32'(halted), 0);
    repeat (12) @(negedge clk);
    check("R1 idle pc", 32'(dbg_pc), 0);
    check("R1 idle we", 32'(mem_we), 0);
  endtask

  task automatic t_halt_restart();
    int t;
    fill_halt();
    do_reset();
    run_prog(t);
    check("R10 halt ticks", 32'(t), 4);
    check("R9 halt pc", 32'(dbg_pc), 1);
    repeat (20) @(negedge clk);
    check("R9 pc frozen", 32'(dbg_pc), 1);
    check("R9 still halted", 32'(halted), 1);
    run_prog(t);
    check("R9 resume pc", 32'(dbg_pc), 2);
    check("R9 resume ticks", 32'(t), 4);
  endtask

  task automatic t_arith();
    int t, w0;
    fill_halt();
    poke(1, ins(2, 20)); poke(2, ins(4, 21)); poke(3, ins(3, 22));
    poke(4, ins(2, 22)); poke(5, ins(7, 0));
    poke(20, -32'sd10); poke(21, 32'd3); poke(22, 32'd0);
    do_reset();
    w0 = wr_cnt;
    run_prog(t);
    check("R5 stored diff", mem[22], 32'd7);
    check("R5 one write", 32'(wr_cnt - w0), 1);
    check("R3 negated reload", dbg_acc, -32'sd7);
    check("R10 five-instr ticks", 32'(t), 36);
    check("R9 arith pc", 32'(dbg_pc), 5);
  endtask

  task automatic t_jump_ind();
    int t;
    fill_halt();
    poke(1, ins(0, 10)); poke(10, 32'd5);
    poke(6, ins(2, 20)); poke(20, -32'sd42);
    do_reset();
    run_prog(t);
    check("R6 jump lands at value+1", 32'(dbg_pc), 7);
    check("R6 target executed", dbg_acc, 32'd42);
    check("R10 jump ticks", 32'(t), 20);
  endtask

  task automatic t_jump_rel();
    int t;
    fill_halt();
    poke(1, ins(1, 10)); poke(10, 32'd3);
    poke(5, ins(2, 20)); poke(20, -32'sd1);
    do_reset();
    run_prog(t);
    check("R7 relative pc", 32'(dbg_pc), 6);
    check("R7 target executed", dbg_acc, 32'd1);
  endtask

  task automatic t_skip();
    int t;
    fill_halt();
    poke(1, ins(2, 20)); poke(2, ins(6, 0)); poke(4, ins(2, 21));
    poke(20, 32'd5); poke(21, -32'sd8);
    do_reset();
    run_prog(t);
    check("R8 taken pc", 32'(dbg_pc), 5);
    check("R8 taken acc", dbg_acc, 32'd8);
    poke(20, -32'sd5);
    do_reset();
    run_prog(t);
    check("R8 not taken pc", 32'(dbg_pc), 3);
    check("R8 not taken acc", dbg_acc, 32'd5);
  endtask

  task automatic t_fields();
    int t;
    fill_halt();
    poke(1, 32'hABCD_0000 | ins(2, 32'h1FF4));
    poke(2, 32'h5A5A_0000 | ins(5, 32'h0FF5));
    poke(3, 32'hFFFF_0000 | ins(7, 32'h1FFF));
    poke(20, 32'd100); poke(21, 32'd7);
    do_reset();
    run_prog(t);
    check("R2 ignored bits + R4 code5 acc", dbg_acc, -32'sd107);
    check("R2 halt with junk bits pc", 32'(dbg_pc), 3);
  endtask

  task automatic t_wrap();
    int t;
    fill_halt();
    poke(1, ins(2, 20)); poke(2, ins(4, 21)); poke(3, ins(0, 22));
    poke(31, ins(3, 23));
    poke(20, 32'h8000_0000); poke(21, 32'd1); poke(22, 32'd30); poke(23, 32'd0);
    do_reset();
    run_prog(t);
    check("R11 pc wrapped to 0", 32'(dbg_pc), 0);
    check("R4 wrap sub", dbg_acc, 32'h7FFF_FFFF);
    check("R11 store at 31 ran", mem[23], 32'h7FFF_FFFF);
    check("R10 wrap ticks", 32'(t), 36);
  endtask

  task automatic t_min_neg();
    int t;
    fill_halt();
    poke(1, ins(2, 20)); poke(20, 32'h8000_0000);
    do_reset();
    run_prog(t);
    check("R3 negate most negative", dbg_acc, 32'h8000_0000);
  endtask

  task automatic t_mid_reset();
    fill_halt();
    poke(1, ins(2, 20)); poke(2, ins(0, 21));
    poke(20, -32'sd9); poke(21, 32'd0);
    do_reset();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    check("R1 loop running", 32'(halted), 0);
    check("R3 loop acc", dbg_acc, 32'd9);
    do_reset();
    check("R1 mid reset pc", 32'(dbg_pc), 0);
    check("R1 mid reset acc", dbg_acc, 0);
    check("R1 mid reset ir", dbg_ir, 0);
    repeat (10) @(negedge clk);
    check("R1 idle after reset", 32'(dbg_pc), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 32'h0000_E000;
    t_reset();
    t_halt_restart();
    t_arith();
    t_jump_ind();
    t_jump_rel();
    t_skip();
    t_fields();
    t_wrap();
    t_min_neg();
    t_mid_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule